// File: doc/BRIEF.md
# Split-Carry Symmetric Pre-Adder

This block forms the sum of the two data samples that are multiplied by the same coefficient in a linear-phase direct-form FIR filter. Folding the symmetric taps this way roughly halves the number of coefficient products the filter needs. To keep the critical path short at very high sample rates, the add is not one carry-propagate adder. The data word is cut into independent groups of `GRP_W` bits. No carry crosses a group boundary, and each group delivers its own carry-out. The downstream partial-product tree then takes each group result as a short number at a known bit weight.

Inside a group, the adder is a ripple chain: a half adder at the lowest data bit and full adders above it. Pipeline registers break the chain so that no more than `CELLS` adder cells sit between two register boundaries. At each cut, the carry and the operand bits not yet consumed are registered. A parameter selects the output mode. In the aligned mode, every group result belongs to the same input sample. In the skewed mode, each sum bit is taken from the register right after the cell that produced it, so low bits appear earlier than high bits. Setting `GRP_W` equal to `DATA_W` yields a single full-width symmetric adder.

Top module: `sym_preadd_top`

## Requirements
- R1: While `rst` is high on a rising edge, `out_valid` and every bit of `grp_sum` are 0 after that edge, whatever the inputs are.
- R2: In aligned mode, let each group field be weighted by 2 to the power of its offset and the weighted fields be summed. The result equals `a + b` of the sample presented `1 + ceil(GRP_W/CELLS)` cycles earlier.
- R3: Group m covers data bits m*GRP_W upward, and its field is the `GRP_W+1`-bit value a_m + b_m. Bit `GRP_W` of the field is that group's own carry-out. A carry out of a lower group never changes a higher group's field.
- R4: When `DATA_W` is not a multiple of `GRP_W`, the top group is narrower and holds the remaining `DATA_W mod GRP_W` bits. The field bits above its carry-out are always 0.
- R5: `grp_ofs` field m (each `$clog2(DATA_W)+1` bits wide, field 0 lowest) holds the constant bit weight m*GRP_W.
- R6: `out_valid` equals `in_valid` delayed by `1 + ceil(GRP_W/CELLS)` cycles. A sample presented with `in_valid` low produces `out_valid` low.
- R7: In skewed mode, sum bit j of a group holds the corresponding bit of a_m + b_m for the sample presented `2 + floor(j/CELLS)` cycles earlier. The group carry-out holds that sample's carry `2 + floor((w-1)/CELLS)` cycles later, where w is the group width.
- R8: With `GRP_W = DATA_W`, there is one group at offset 0, and its field equals the full `DATA_W+1`-bit sum `a + b` after `1 + ceil(DATA_W/CELLS)` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid sample pair |
| a | input | DATA_W | First symmetric sample, unsigned |
| b | input | DATA_W | Second symmetric sample, unsigned |
| out_valid | output | 1 | Marks valid aligned group results |
| grp_sum | output | NGRP*(GRP_W+1) | Group results, group 0 in the low field |
| grp_ofs | output | NGRP*($clog2(DATA_W)+1) | Bit weight of each group field |

## Verification
There is one input register, followed by `ceil(GRP_W/CELLS)` stage registers. An aligned result is therefore due `1 + ceil(GRP_W/CELLS)` cycles after its sample: 3 cycles for the 8/3/2 configuration and 4 for the 8/8/3 full-width one. A skewed bit j is due `2 + floor(j/CELLS)` cycles after its sample. The bench drives one sample per cycle on the falling edge. It keeps a history of every sample it drove. Before driving the next sample, it compares each output against the history entry exactly that many cycles old. The sweep covers all 65,536 operand pairs, with invalid gaps mixed in.

// File: rtl/spa_pkg.sv
package spa_pkg;

  // ceiling division for positive integers
  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  // one adder cell: returns {carry, sum}; with ci tied low it acts as a half adder
  function automatic logic [1:0] add_cell(input logic x, input logic y, input logic ci);
    return {(x & y) | (x & ci) | (y & ci), x ^ y ^ ci};
  endfunction

endpackage

// File: rtl/spa_group.sv
module spa_group
  import spa_pkg::*;
#(
  parameter int W     = 3,
  parameter int CELLS = 2,
  parameter int NSTG  = 2,
  parameter int ALIGN = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   sum
);

  // stage registers; index s is the register after adder level s
  logic [W-1:0] st_x [NSTG];
  logic [W-1:0] st_y [NSTG];
  logic [W-1:0] st_s [NSTG];
  logic         st_c [NSTG];

  logic [W-1:0] nx_x [NSTG];
  logic [W-1:0] nx_y [NSTG];
  logic [W-1:0] nx_s [NSTG];
  logic         nx_c [NSTG];

  // ripple cells of each level: bit j belongs to level j/CELLS
  always_comb begin
    for (int s = 0; s < NSTG; s++) begin
      logic [W-1:0] ox, oy, os;
      logic         c;
      logic [1:0]   cs;
      cs = '0;
      ox = (s == 0) ? x : st_x[(s == 0) ? 0 : s - 1];
      oy = (s == 0) ? y : st_y[(s == 0) ? 0 : s - 1];
      os = (s == 0) ? '0 : st_s[(s == 0) ? 0 : s - 1];
      c  = (s == 0) ? 1'b0 : st_c[(s == 0) ? 0 : s - 1];
      for (int j = 0; j < W; j++) begin
        if (j / CELLS == s) begin
          cs    = add_cell(ox[j], oy[j], c);
          os[j] = cs[0];
          c     = cs[1];
        end
      end
      nx_x[s] = ox;
      nx_y[s] = oy;
      nx_s[s] = os;
      nx_c[s] = c;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTG; s++) begin
      if (rst) begin
        st_x[s] <= '0;
        st_y[s] <= '0;
        st_s[s] <= '0;
        st_c[s] <= 1'b0;
      end else begin
        st_x[s] <= nx_x[s];
        st_y[s] <= nx_y[s];
        st_s[s] <= nx_s[s];
        st_c[s] <= nx_c[s];
      end
    end
  end

  if (ALIGN != 0) begin : g_aligned
    assign sum = {st_c[NSTG-1], st_s[NSTG-1]};
  end else begin : g_skewed
    always_comb begin
      for (int j = 0; j < W; j++) begin
        sum[j] = st_s[j / CELLS][j];
      end
      sum[W] = st_c[(W - 1) / CELLS];
    end
  end

endmodule

// File: rtl/sym_preadd_top.sv
module sym_preadd_top
  import spa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3,
  parameter int CELLS  = 2,
  parameter int ALIGN  = 1,
  localparam int NGRP  = cdiv(DATA_W, GRP_W),
  localparam int FLD_W = GRP_W + 1,
  localparam int OFS_W = $clog2(DATA_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  output logic                    out_valid,
  output logic [NGRP*FLD_W-1:0]   grp_sum,
  output logic [NGRP*OFS_W-1:0]   grp_ofs
);

  localparam int NSTG = cdiv(GRP_W, CELLS);

  // input register: the level-0 boundary of every group chain
  logic [DATA_W-1:0] a_q, b_q;
  logic              v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
      v_q <= in_valid;
    end
  end

  // valid travels beside the widest group's stages
  logic [NSTG-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= v_q;
      for (int i = 1; i < NSTG; i++) begin
        vpipe[i] <= vpipe[i-1];
      end
    end
  end

  assign out_valid = vpipe[NSTG-1];

  for (genvar m = 0; m < NGRP; m++) begin : g_grp
    localparam int LO = m * GRP_W;
    localparam int W  = (DATA_W - LO < GRP_W) ? DATA_W - LO : GRP_W;
    logic [W:0] gs;

    spa_group #(
      .W     (W),
      .CELLS (CELLS),
      .NSTG  (NSTG),
      .ALIGN (ALIGN)
    ) u_grp (
      .clk (clk),
      .rst (rst),
      .x   (a_q[LO +: W]),
      .y   (b_q[LO +: W]),
      .sum (gs)
    );

    if (W < GRP_W) begin : g_narrow
      assign grp_sum[m*FLD_W +: FLD_W] = {{(GRP_W - W){1'b0}}, gs};
    end else begin : g_full
      assign grp_sum[m*FLD_W +: FLD_W] = gs;
    end

    assign grp_ofs[m*OFS_W +: OFS_W] = OFS_W'(LO);
  end

endmodule

// File: rtl/spa_checker.sv
module spa_checker
  import spa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3,
  parameter int CELLS  = 2,
  parameter int ALIGN  = 1,
  localparam int NGRP  = cdiv(DATA_W, GRP_W),
  localparam int FLD_W = GRP_W + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [DATA_W-1:0]     a,
  input logic [DATA_W-1:0]     b,
  input logic                  out_valid,
  input logic [NGRP*FLD_W-1:0] grp_sum
);

  localparam int LAT    = 1 + cdiv(GRP_W, CELLS);
  localparam int LAST_W = DATA_W - (NGRP - 1) * GRP_W;

  logic [LAT-1:0] vp;
  logic [DATA_W:0] sp [LAT];
  logic [DATA_W:0] wsum;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp <= '0;
    end else begin
      vp <= {vp[LAT-2:0], in_valid};
    end
    sp[0] <= (DATA_W+1)'(a) + (DATA_W+1)'(b);
    for (int i = 1; i < LAT; i++) begin
      sp[i] <= sp[i-1];
    end
  end

  always_comb begin
    wsum = '0;
    for (int m = 0; m < NGRP; m++) begin
      wsum = wsum + ((DATA_W+1)'(grp_sum[m*FLD_W +: FLD_W]) << (m * GRP_W));
    end
  end

  // R1: reset clears results
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && grp_sum == '0));

  // R6: valid delay
  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid == vp[LAT-1]);

  if (ALIGN != 0) begin : g_al
    // R2: weighted group fields reproduce the full sum
    assert_weighted_sum_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> wsum == sp[LAT-1]);

    for (genvar m = 0; m < NGRP; m++) begin : g_rng
      localparam int W = (m == NGRP - 1) ? LAST_W : GRP_W;
      // R3: each field stays within the range of a two-operand w-bit sum
      assert_group_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(grp_sum[m*FLD_W +: FLD_W]) <= 2 * ((1 << W) - 1));
    end
  end

  if (LAST_W < GRP_W) begin : g_pad
    // R4: padding above the narrow group's carry stays zero
    assert_narrow_pad_R4: assert property (@(posedge clk) disable iff (rst)
      grp_sum[NGRP*FLD_W-1 -: (GRP_W - LAST_W)] == '0);
  end

endmodule

bind sym_preadd_top spa_checker #(
  .DATA_W (DATA_W),
  .GRP_W  (GRP_W),
  .CELLS  (CELLS),
  .ALIGN  (ALIGN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .grp_sum   (grp_sum)
);

// File: tb/sim_sym_preadd_top.sv
module sim_sym_preadd_top;

  localparam int DW  = 8;
  localparam int S   = 3;
  localparam int K   = 2;
  localparam int NG  = 3;
  localparam int FW  = S + 1;
  localparam int OW  = 4;
  localparam int L0  = 1 + (S + K - 1) / K;   // 3
  localparam int S2  = 8;
  localparam int K2  = 3;
  localparam int L2  = 1 + (S2 + K2 - 1) / K2; // 4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] a = '0, b = '0;

  logic v0, v1, v2;
  logic [NG*FW-1:0] sum0, sum1;
  logic [NG*OW-1:0] ofs0, ofs1;
  logic [S2:0] sum2;
  logic [OW-1:0] ofs2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sym_preadd_top #(.DATA_W(DW), .GRP_W(S), .CELLS(K), .ALIGN(1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v0), .grp_sum(sum0), .grp_ofs(ofs0));

  sym_preadd_top #(.DATA_W(DW), .GRP_W(S), .CELLS(K), .ALIGN(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v1), .grp_sum(sum1), .grp_ofs(ofs1));

  sym_preadd_top #(.DATA_W(DW), .GRP_W(S2), .CELLS(K2), .ALIGN(1)) u2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v2), .grp_sum(sum2), .grp_ofs(ofs2));

  logic [DW-1:0] ha [32];
  logic [DW-1:0] hb [32];
  logic          hv [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] get_a(input int t);
    return (t < 0) ? '0 : ha[t & 31];
  endfunction
  function automatic logic [DW-1:0] get_b(input int t);
    return (t < 0) ? '0 : hb[t & 31];
  endfunction
  function automatic logic get_v(input int t);
    return (t < 0) ? 1'b0 : hv[t & 31];
  endfunction

  function automatic int gwidth(input int m);
    return (m == NG - 1) ? DW - (NG - 1) * S : S;
  endfunction

  function automatic int gpart(input logic [DW-1:0] x, input int m);
    return int'((x >> (m * S)) & ((1 << gwidth(m)) - 1));
  endfunction

  task automatic check_cycle(input int t);
    int wsum;
    // aligned instance, latency L0
    chk("R6", 32'(v0), 32'(get_v(t - L0)));
    if (get_v(t - L0)) begin
      wsum = 0;
      for (int m = 0; m < NG; m++) wsum += int'(sum0[m*FW +: FW]) << (m * S);
      chk("R2", 32'(wsum), 32'(get_a(t - L0)) + 32'(get_b(t - L0)));
      for (int m = 0; m < NG; m++) begin
        int e;
        e = gpart(get_a(t - L0), m) + gpart(get_b(t - L0), m);
        if (gwidth(m) < S) chk("R4 narrow group", 32'(sum0[m*FW +: FW]), 32'(e));
        else               chk("R3 group field",  32'(sum0[m*FW +: FW]), 32'(e));
      end
    end
    // full-width instance, latency L2
    chk("R8 valid", 32'(v2), 32'(get_v(t - L2)));
    if (get_v(t - L2))
      chk("R8 sum", 32'(sum2), 32'(get_a(t - L2)) + 32'(get_b(t - L2)));
    // skewed instance: bit j due 2 + j/K cycles after its sample
    for (int m = 0; m < NG; m++) begin
      int w;
      int ef;
      w  = gwidth(m);
      ef = 0;
      for (int j = 0; j <= w; j++) begin
        int d;
        int gs;
        d  = (j < w) ? 2 + j / K : 2 + (w - 1) / K;
        gs = gpart(get_a(t - d), m) + gpart(get_b(t - d), m);
        ef |= ((gs >> j) & 1) << j;
      end
      chk("R7 skewed field", 32'(sum1[m*FW +: FW]), 32'(ef));
    end
  endtask

  initial begin
    int t;
    int idx;
    int tail;
    for (int i = 0; i < 32; i++) begin
      ha[i] = '0; hb[i] = '0; hv[i] = 1'b0;
    end
    // reset with busy inputs: reset must dominate (R1)
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid", 32'(v0), 32'd0);
    chk("R1 sum",   32'(sum0), 32'd0);
    chk("R1 skewed sum", 32'(sum1), 32'd0);
    chk("R1 full sum", 32'(sum2), 32'd0);
    // R5: offsets m*S
    for (int m = 0; m < NG; m++) chk("R5 offset", 32'(ofs0[m*OW +: OW]), 32'(m * S));
    chk("R8 offset", 32'(ofs2), 32'd0);
    a = '0; b = '0; in_valid = 1'b0;
    rst = 1'b0;
    t = 0; idx = 0; tail = 0;
    while (tail < 8) begin
      @(negedge clk);
      check_cycle(t);
      if (idx < 65536 && (t % 11) != 7) begin
        a = DW'(idx >> DW);
        b = DW'(idx);
        in_valid = 1'b1;
        idx++;
      end else begin
        a = DW'(t * 37);
        b = DW'(t * 91);
        in_valid = 1'b0;
        if (idx >= 65536) tail++;
      end
      ha[t & 31] = a; hb[t & 31] = b; hv[t & 31] = in_valid;
      t++;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule